// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execute stage of a small 8-bit processor core. It holds the accumulator, the two index registers and the processor status byte. Each cycle it is given an operation class and an 8-bit operand from the data path. When the execute qualifier is high, it applies the operation and commits every register change on that clock edge. Fetch, addressing, branching and stack-pointer handling live elsewhere. The block only sees the operand that those stages deliver.

Arithmetic covers add and subtract with carry in both binary and packed-BCD form, where the decimal bit of the status byte selects the form. The other operations are logical AND and OR, a bit test, shifts and rotates on either the accumulator or the operand, increments, and register loads. Status-byte operations restore the whole byte from the operand or set the break bit. A registered result output carries the value an operation produces, so that the surrounding core can write it back to memory.

`exec_en` is a plain qualifier and not a handshake. The block accepts an operation on every cycle where the qualifier is high, and it never applies back-pressure. When the qualifier is low, all state holds.

Top module: `acc_alu`

## Requirements
- R1: Synchronous reset clears A, X, Y and the result register and loads the status byte with 0x20. The status byte bits are: carry at bit 0, zero at bit 1, decimal at bit 3, break at bit 4, a constant one at bit 5, overflow at bit 6 and negative at bit 7. Bit 5 reads as one at all times.
- R2: While `exec_en` is low, A, X, Y, status and result keep their values whatever `op` and `m_in` carry.
- R3: Add (op 1) with decimal clear writes A + M + C to A and to result. C becomes the carry out of bit 7, V becomes NOT(A7 XOR M7) AND (A7 XOR R7), N becomes R7, and Z is set only when R is 0x00.
- R4: Subtract (op 2) with decimal clear writes A - M - 1 + C to A and to result. C is set when no borrow occurs, V becomes (A7 XOR M7) AND (A7 XOR R7), N becomes R7, and Z is set only when R is 0x00.
- R5: Add with decimal set writes the BCD sum to A and to result. A low-nibble sum above 9 gets 6 added. A high part above 0x9F gets 0x60 added, and this case also sets C. N, V and Z follow the binary sum.
- R6: Subtract with decimal set corrects each nibble. A negative low difference gets 6 removed and borrows from the high difference. A negative high difference gets 0x60 removed. C, N, V and Z follow the binary difference.
- R7: AND (op 3) and OR (op 4) combine A with M into A and into result, and set Z and N from the value.
- R8: Bit test (op 5) sets Z when (A AND M) is 0, copies M7 into N and M6 into V, and leaves A, C and result unchanged.
- R9: The shift ops each come in two forms. The accumulator form (ASL 6, LSR 8, ROL 10, ROR 12) writes A and result. The operand form (7, 9, 11, 13) writes only result. The bit shifted out goes to C. A rotate moves the old C into the vacated bit. N and Z follow the value, so LSR always clears N.
- R10: Increment-operand (op 14) puts M + 1 on result. INX (15) and INY (16) increment X or Y without touching result. All three set Z and N from the new value.
- R11: The loads LDA (17), LDX (18) and LDY (19) and the pull PLA (20) copy M into the target register and result, and set Z and N. The push PHA (21) puts A on result and changes no flag.
- R12: Status restore (op 22) loads the status byte with M OR 0x20. Break (op 23) sets bit 4 and leaves the other bits alone. Op 0 and all undefined codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Commit the operation on this edge |
| op | input | 5 | Operation class code (see requirements) |
| m_in | input | 8 | Operand from the data path |
| result | output | 8 | Registered result value |
| a_reg | output | 8 | Accumulator |
| x_reg | output | 8 | X index register |
| y_reg | output | 8 | Y index register |
| status | output | 8 | Processor status byte |

## Verification
The properties assume that `op` and `m_in` hold defined, non-X values whenever `exec_en` is high at a clock edge. They also assume that the decimal bit seen in `status` during that cycle is the one the operation uses. The bench changes inputs only at falling edges and uses only the listed codes. It places every flag it needs, including carry and decimal, with a status-restore operation before each arithmetic case. Every flag a case depends on is therefore known when that case runs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NIB = DW / 2;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,  OP_ADC   = 5'd1,  OP_SBC   = 5'd2,  OP_AND   = 5'd3,
    OP_ORA   = 5'd4,  OP_BIT   = 5'd5,  OP_ASL_A = 5'd6,  OP_ASL_M = 5'd7,
    OP_LSR_A = 5'd8,  OP_LSR_M = 5'd9,  OP_ROL_A = 5'd10, OP_ROL_M = 5'd11,
    OP_ROR_A = 5'd12, OP_ROR_M = 5'd13, OP_INC_M = 5'd14, OP_INX   = 5'd15,
    OP_INY   = 5'd16, OP_LDA   = 5'd17, OP_LDX   = 5'd18, OP_LDY   = 5'd19,
    OP_PLA   = 5'd20, OP_PHA   = 5'd21, OP_RTI   = 5'd22, OP_BRK   = 5'd23
  } alu_op_e;

  typedef enum logic [1:0] {SH_ASL, SH_LSR, SH_ROL, SH_ROR} shift_kind_e;

  localparam int P_C   = 0;
  localparam int P_Z   = 1;
  localparam int P_D   = 3;
  localparam int P_B   = 4;
  localparam int P_ONE = 5;
  localparam int P_V   = 6;
  localparam int P_N   = 7;
  localparam logic [DW-1:0] P_RESET = DW'(1) << P_ONE;
endpackage

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] v_i,
  input  logic          c_i,
  input  shift_kind_e   kind_i,
  output logic [DW-1:0] r_o,
  output logic          c_o
);
  always_comb begin
    unique case (kind_i)
      SH_ASL: begin r_o = {v_i[DW-2:0], 1'b0}; c_o = v_i[DW-1]; end
      SH_LSR: begin r_o = {1'b0, v_i[DW-1:1]}; c_o = v_i[0];    end
      SH_ROL: begin r_o = {v_i[DW-2:0], c_i};  c_o = v_i[DW-1]; end
      default: begin r_o = {c_i, v_i[DW-1:1]}; c_o = v_i[0];    end
    endcase
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          dec_i,
  input  logic          sub_i,
  output logic [DW-1:0] bin_o,
  output logic [DW-1:0] out_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int WW = DW + 2;

  logic [DW:0]   sum_w, dif_w;
  logic [DW-1:0] dec_val;
  logic          dec_carry;

  assign sum_w = {1'b0, a_i} + {1'b0, m_i} + {{DW{1'b0}}, c_i};
  assign dif_w = {1'b0, a_i} - {1'b0, m_i} - {{DW{1'b0}}, ~c_i};
  assign bin_o = sub_i ? dif_w[DW-1:0] : sum_w[DW-1:0];

  assign v_o = sub_i ? ((a_i[DW-1] ^ m_i[DW-1]) & (a_i[DW-1] ^ bin_o[DW-1]))
                     : (~(a_i[DW-1] ^ m_i[DW-1]) & (a_i[DW-1] ^ bin_o[DW-1]));

  generate
    if (DECIMAL_EN) begin : g_bcd
      logic [NIB+1:0] lo_add, lo_add_fix;
      logic [WW-1:0]  hi_add, hi_add_fix, lo_sub, hi_sub;
      always_comb begin
        lo_add     = {2'b00, a_i[NIB-1:0]} + {2'b00, m_i[NIB-1:0]} + {{(NIB+1){1'b0}}, c_i};
        lo_add_fix = (lo_add > (NIB+2)'(9)) ? lo_add + (NIB+2)'(6) : lo_add;
        hi_add     = {2'b00, a_i[DW-1:NIB], {NIB{1'b0}}} + {2'b00, m_i[DW-1:NIB], {NIB{1'b0}}}
                   + (lo_add_fix[NIB] ? WW'(16) : WW'(0));
        hi_add_fix = (hi_add > WW'(8'h9F)) ? hi_add + WW'(8'h60) : hi_add;

        lo_sub = {{(WW-NIB){1'b0}}, a_i[NIB-1:0]} - {{(WW-NIB){1'b0}}, m_i[NIB-1:0]}
               - {{(WW-1){1'b0}}, ~c_i};
        hi_sub = {2'b00, a_i[DW-1:NIB], {NIB{1'b0}}} - {2'b00, m_i[DW-1:NIB], {NIB{1'b0}}};
        if (lo_sub[NIB]) begin
          lo_sub = lo_sub - WW'(6);
          hi_sub = hi_sub - WW'(1);
        end
        if (hi_sub[DW]) hi_sub = hi_sub - WW'(8'h60);

        dec_val   = sub_i ? {hi_sub[DW-1:NIB], lo_sub[NIB-1:0]}
                          : {hi_add_fix[DW-1:NIB], lo_add_fix[NIB-1:0]};
        dec_carry = hi_add > WW'(8'h9F);
      end
    end else begin : g_bin
      assign dec_val   = bin_o;
      assign dec_carry = sum_w[DW];
    end
  endgenerate

  assign out_o = dec_i ? dec_val : bin_o;
  assign c_o   = sub_i ? ~dif_w[DW] : (dec_i ? dec_carry : sum_w[DW]);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  logic [4:0]   op,
  input  logic [7:0]   m_in,
  output logic [7:0]   result,
  output logic [7:0]   a_reg,
  output logic [7:0]   x_reg,
  output logic [7:0]   y_reg,
  output logic [7:0]   status
);
  alu_op_e       opc;
  logic [DW-1:0] r_a, r_x, r_y, r_p, r_res;
  logic [DW-1:0] n_a, n_x, n_y, n_p, n_res;
  logic [DW-1:0] as_bin, as_out, sh_src, sh_res;
  logic          as_c, as_v, sh_c, sh_mem;
  shift_kind_e   sh_kind;

  assign opc = alu_op_e'(op);

  function automatic logic [DW-1:0] with_zn(input logic [DW-1:0] p, input logic [DW-1:0] v);
    logic [DW-1:0] q;
    q      = p;
    q[P_Z] = (v == '0);
    q[P_N] = v[DW-1];
    return q;
  endfunction

  always_comb begin
    sh_mem  = 1'b0;
    sh_kind = SH_ASL;
    case (opc)
      OP_ASL_M: begin sh_kind = SH_ASL; sh_mem = 1'b1; end
      OP_LSR_A: sh_kind = SH_LSR;
      OP_LSR_M: begin sh_kind = SH_LSR; sh_mem = 1'b1; end
      OP_ROL_A: sh_kind = SH_ROL;
      OP_ROL_M: begin sh_kind = SH_ROL; sh_mem = 1'b1; end
      OP_ROR_A: sh_kind = SH_ROR;
      OP_ROR_M: begin sh_kind = SH_ROR; sh_mem = 1'b1; end
      default:  sh_kind = SH_ASL;
    endcase
  end

  assign sh_src = sh_mem ? m_in : r_a;

  acc_alu_shift u_shift (
    .v_i    (sh_src),
    .c_i    (r_p[P_C]),
    .kind_i (sh_kind),
    .r_o    (sh_res),
    .c_o    (sh_c)
  );

  acc_alu_addsub #(.DECIMAL_EN(DECIMAL_EN)) u_addsub (
    .a_i   (r_a),
    .m_i   (m_in),
    .c_i   (r_p[P_C]),
    .dec_i (r_p[P_D]),
    .sub_i (opc == OP_SBC),
    .bin_o (as_bin),
    .out_o (as_out),
    .c_o   (as_c),
    .v_o   (as_v)
  );

  always_comb begin
    n_a = r_a; n_x = r_x; n_y = r_y; n_p = r_p; n_res = r_res;
    case (opc)
      OP_ADC, OP_SBC: begin
        n_a = as_out; n_res = as_out;
        n_p = with_zn(r_p, as_bin);
        n_p[P_C] = as_c; n_p[P_V] = as_v;
      end
      OP_AND: begin n_a = r_a & m_in; n_res = r_a & m_in; n_p = with_zn(r_p, r_a & m_in); end
      OP_ORA: begin n_a = r_a | m_in; n_res = r_a | m_in; n_p = with_zn(r_p, r_a | m_in); end
      OP_BIT: begin
        n_p[P_Z] = ((r_a & m_in) == '0);
        n_p[P_N] = m_in[P_N];
        n_p[P_V] = m_in[P_V];
      end
      OP_ASL_A, OP_LSR_A, OP_ROL_A, OP_ROR_A: begin
        n_a = sh_res; n_res = sh_res;
        n_p = with_zn(r_p, sh_res); n_p[P_C] = sh_c;
      end
      OP_ASL_M, OP_LSR_M, OP_ROL_M, OP_ROR_M: begin
        n_res = sh_res;
        n_p = with_zn(r_p, sh_res); n_p[P_C] = sh_c;
      end
      OP_INC_M: begin n_res = m_in + DW'(1); n_p = with_zn(r_p, m_in + DW'(1)); end
      OP_INX:   begin n_x = r_x + DW'(1); n_p = with_zn(r_p, r_x + DW'(1)); end
      OP_INY:   begin n_y = r_y + DW'(1); n_p = with_zn(r_p, r_y + DW'(1)); end
      OP_LDA, OP_PLA: begin n_a = m_in; n_res = m_in; n_p = with_zn(r_p, m_in); end
      OP_LDX:   begin n_x = m_in; n_res = m_in; n_p = with_zn(r_p, m_in); end
      OP_LDY:   begin n_y = m_in; n_res = m_in; n_p = with_zn(r_p, m_in); end
      OP_PHA:   n_res = r_a;
      OP_RTI:   n_p = m_in | P_RESET;
      OP_BRK:   n_p[P_B] = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_a <= '0; r_x <= '0; r_y <= '0; r_res <= '0; r_p <= P_RESET;
    end else if (exec_en) begin
      r_a <= n_a; r_x <= n_x; r_y <= n_y; r_res <= n_res; r_p <= n_p;
    end
  end

  assign result = r_res;
  assign a_reg  = r_a;
  assign x_reg  = r_x;
  assign y_reg  = r_y;
  assign status = r_p;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       exec_en,
  input logic [4:0] op,
  input logic [7:0] m_in,
  input logic [7:0] result,
  input logic [7:0] a_reg,
  input logic [7:0] x_reg,
  input logic [7:0] y_reg,
  input logic [7:0] status
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (a_reg == 8'h00 && x_reg == 8'h00 && y_reg == 8'h00 &&
             result == 8'h00 && status == 8'h20));

  assert_one_bit_R1: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> status[P_ONE]);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(a_reg) && $stable(x_reg) && $stable(y_reg) &&
                  $stable(status) && $stable(result)));

  assert_add_binary_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == OP_ADC && !status[P_D]) |=>
      ({status[P_C], a_reg} == $past({1'b0, a_reg} + {1'b0, m_in} + {8'd0, status[P_C]})));

  assert_sub_binary_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == OP_SBC && !status[P_D]) |=>
      (a_reg == $past(a_reg - m_in - {7'd0, ~status[P_C]})));

  assert_bit_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == OP_BIT) |=>
      (status[P_N] == $past(m_in[7]) && status[P_V] == $past(m_in[6]) && $stable(a_reg)));

  assert_lsr_clears_n_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op == OP_LSR_A || op == OP_LSR_M)) |=> !status[P_N]);

  assert_load_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op == OP_LDA || op == OP_PLA)) |=>
      (status[P_Z] == (result == 8'h00) && a_reg == result));

  assert_restore_R12: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == OP_RTI) |=> (status == ($past(m_in) | 8'h20)));

  assert_break_R12: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == OP_BRK) |=> (status == ($past(status) | 8'h10)));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .exec_en (exec_en),
  .op      (op),
  .m_in    (m_in),
  .result  (result),
  .a_reg   (a_reg),
  .x_reg   (x_reg),
  .y_reg   (y_reg),
  .status  (status)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  import acc_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] m_in = 8'h00;
  logic [7:0] result, a_reg, x_reg, y_reg, status;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  acc_alu uut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op(op), .m_in(m_in),
    .result(result), .a_reg(a_reg), .x_reg(x_reg), .y_reg(y_reg), .status(status)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input alu_op_e o, input logic [7:0] m);
    @(negedge clk);
    op = o; m_in = m; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "A", a_reg, 8'h00);
    chk("R1", "X", x_reg, 8'h00);
    chk("R1", "Y", y_reg, 8'h00);
    chk("R1", "result", result, 8'h00);
    chk("R1", "status", status, 8'h20);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op = OP_LDA; m_in = 8'h55; exec_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "A idle", a_reg, 8'h00);
    chk("R2", "result idle", result, 8'h00);
    chk("R2", "status idle", status, 8'h20);
  endtask

  task automatic t_add_bin;
    do_op(OP_RTI, 8'h20); do_op(OP_LDA, 8'h7F); do_op(OP_ADC, 8'h01);
    chk("R3", "A 7F+01", a_reg, 8'h80);
    chk("R3", "P 7F+01", status, 8'hE0);
    do_op(OP_RTI, 8'h20); do_op(OP_LDA, 8'hFF); do_op(OP_ADC, 8'h01);
    chk("R3", "result FF+01", result, 8'h00);
    chk("R3", "P FF+01", status, 8'h23);
  endtask

  task automatic t_sub_bin;
    do_op(OP_RTI, 8'h21); do_op(OP_LDA, 8'h80); do_op(OP_SBC, 8'h01);
    chk("R4", "A 80-01", a_reg, 8'h7F);
    chk("R4", "P 80-01", status, 8'h61);
    do_op(OP_RTI, 8'h20); do_op(OP_LDA, 8'h05); do_op(OP_SBC, 8'h05);
    chk("R4", "A 05-05-borrow", a_reg, 8'hFF);
    chk("R4", "P 05-05-borrow", status, 8'hA0);
  endtask

  task automatic t_add_dec;
    do_op(OP_RTI, 8'h29); do_op(OP_LDA, 8'h58); do_op(OP_ADC, 8'h46);
    chk("R5", "A 58+46+1", a_reg, 8'h05);
    chk("R5", "P 58+46+1", status, 8'hE9);
    do_op(OP_RTI, 8'h28); do_op(OP_LDA, 8'h12); do_op(OP_ADC, 8'h34);
    chk("R5", "A 12+34", a_reg, 8'h46);
    chk("R5", "P 12+34", status, 8'h28);
  endtask

  task automatic t_sub_dec;
    do_op(OP_RTI, 8'h29); do_op(OP_LDA, 8'h50); do_op(OP_SBC, 8'h25);
    chk("R6", "A 50-25", a_reg, 8'h25);
    chk("R6", "P 50-25", status, 8'h29);
    do_op(OP_RTI, 8'h29); do_op(OP_LDA, 8'h00); do_op(OP_SBC, 8'h01);
    chk("R6", "A 00-01", a_reg, 8'h99);
    chk("R6", "P 00-01", status, 8'hA8);
  endtask

  task automatic t_logic;
    do_op(OP_RTI, 8'h20); do_op(OP_LDA, 8'hF0); do_op(OP_AND, 8'h0F);
    chk("R7", "A and", a_reg, 8'h00);
    chk("R7", "P and", status, 8'h22);
    do_op(OP_ORA, 8'h81);
    chk("R7", "result or", result, 8'h81);
    chk("R7", "P or", status, 8'hA0);
  endtask

  task automatic t_bit;
    do_op(OP_RTI, 8'h21); do_op(OP_LDA, 8'h0F); do_op(OP_BIT, 8'hC0);
    chk("R8", "A after bit", a_reg, 8'h0F);
    chk("R8", "P bit C0", status, 8'hE3);
    chk("R8", "result after bit", result, 8'h0F);
    do_op(OP_BIT, 8'h01);
    chk("R8", "P bit 01", status, 8'h21);
  endtask

  task automatic t_shift;
    do_op(OP_RTI, 8'h20); do_op(OP_LDA, 8'h81); do_op(OP_ASL_A, 8'h00);
    chk("R9", "A asl", a_reg, 8'h02);
    chk("R9", "P asl", status, 8'h21);
    do_op(OP_ROL_A, 8'h00);
    chk("R9", "A rol", a_reg, 8'h05);
    chk("R9", "P rol", status, 8'h20);
    do_op(OP_ROR_M, 8'h01);
    chk("R9", "result ror mem", result, 8'h00);
    chk("R9", "A kept ror mem", a_reg, 8'h05);
    chk("R9", "P ror mem", status, 8'h23);
    do_op(OP_ROR_A, 8'h00);
    chk("R9", "A ror", a_reg, 8'h82);
    chk("R9", "P ror", status, 8'hA1);
    do_op(OP_LSR_M, 8'h01);
    chk("R9", "P lsr mem", status, 8'h23);
    chk("R9", "A kept lsr mem", a_reg, 8'h82);
    do_op(OP_ASL_M, 8'h40);
    chk("R9", "result asl mem", result, 8'h80);
    chk("R9", "P asl mem", status, 8'hA0);
    do_op(OP_LSR_A, 8'h00);
    chk("R9", "A lsr", a_reg, 8'h41);
    chk("R9", "P lsr", status, 8'h20);
  endtask

  task automatic t_inc;
    do_op(OP_RTI, 8'h20); do_op(OP_INC_M, 8'hFF);
    chk("R10", "result inc FF", result, 8'h00);
    chk("R10", "P inc FF", status, 8'h22);
    do_op(OP_LDX, 8'h7F); do_op(OP_INX, 8'h00);
    chk("R10", "X inx", x_reg, 8'h80);
    chk("R10", "result kept inx", result, 8'h7F);
    chk("R10", "P inx", status, 8'hA0);
    do_op(OP_LDY, 8'hFF); do_op(OP_INY, 8'h00);
    chk("R10", "Y iny", y_reg, 8'h00);
    chk("R10", "P iny", status, 8'h22);
  endtask

  task automatic t_load_stack;
    do_op(OP_RTI, 8'h20); do_op(OP_PLA, 8'h80);
    chk("R11", "A pla", a_reg, 8'h80);
    chk("R11", "P pla", status, 8'hA0);
    do_op(OP_LDX, 8'h00);
    chk("R11", "X ldx", x_reg, 8'h00);
    chk("R11", "P ldx", status, 8'h22);
    do_op(OP_PHA, 8'h11);
    chk("R11", "result pha", result, 8'h80);
    chk("R11", "P pha", status, 8'h22);
  endtask

  task automatic t_status;
    do_op(OP_RTI, 8'h00);
    chk("R12", "P rti 00", status, 8'h20);
    do_op(OP_BRK, 8'h00);
    chk("R12", "P brk", status, 8'h30);
    do_op(OP_RTI, 8'hDF);
    chk("R12", "P rti DF", status, 8'hFF);
    do_op(OP_NOP, 8'h00);
    chk("R12", "P nop", status, 8'hFF);
    do_op(OP_RTI, 8'h01); do_op(alu_op_e'(5'd30), 8'h77);
    chk("R12", "P undefined op", status, 8'h21);
    chk("R12", "A undefined op", a_reg, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_add_bin();
    t_sub_bin();
    t_add_dec();
    t_sub_dec();
    t_logic();
    t_bit();
    t_shift();
    t_inc();
    t_load_stack();
    t_status();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule